// File: doc/BRIEF.md
# PWM Time-Base Counter with Prescaler

This block is the timing heart of a PWM generator. A two-stage prescaler divides the input clock into a slower tick. A 16-bit counter advances on that tick between zero and a programmable period. The counter can count up, count down, count up then down, or freeze. Downstream compare and output-action logic uses the counter value, a zero strobe, a period strobe and a direction flag to build waveforms.

Software writes two words through a single-cycle write port: a control word and a period word. The control word selects the count mode, the prescaler factors, how a period write takes effect, and what the counter does while a debug halt input is high. A period write goes either straight into the active period or into a holding copy. The holding copy moves into the active period when the counter sits at zero.

Top module: `pwm_timebase`

## Requirements
- R1: With control bits [1:0] = 00 the counter adds one on each tick and goes to zero on the tick after it equals or exceeds the period (period 5 gives 0,1,2,3,4,5,0). The direction flag reads 0 (up).
- R2: With control bits [1:0] = 01 the counter subtracts one on each tick and reloads the period on the tick after it reaches zero. The direction flag reads 1 (down).
- R3: With control bits [1:0] = 10 the counter rises to the period, then falls to zero, then rises again (period 3 gives 1,2,3,2,1,0,1). The direction flag shows whether the count is currently falling.
- R4: With control bits [1:0] = 11 the counter holds its value on every tick.
- R5: The tick divides the clock by (1 << D) * H. D is control bits [12:10]. H is 1 when control bits [9:7] are zero and twice that field otherwise. The counter changes only on ticks.
- R6: With control bit 3 = 1 a period write changes the active period on the next clock. With bit 3 = 0 the write lands in a holding copy, which becomes active on a tick at which the counter equals zero.
- R7: While the halt input is high, control bits [15:14] select the behaviour. 00 stops the counter at once. 01 lets it run until it reaches zero and then holds it there. 10 and 11 let it run freely.
- R8: The zero strobe is high exactly while the counter equals zero. The period strobe is high exactly while the counter equals the active period.
- R9: Up mode drives the direction flag to 0 and down mode drives it to 1 on each advancing tick. Freeze leaves the flag unchanged.
- R10: Reset, active low and asynchronous, clears the counter, the prescaler, the control word and both period copies, and sets the direction to up.
- R11: A write with the select input at 0 loads the control word. With the select input at 1 it loads the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_sel_i | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data_i | input | 16 | Write data |
| halt_i | input | 1 | Debug halt request |
| tick_o | output | 1 | Prescaled tick |
| count_o | output | 16 | Counter value |
| zero_o | output | 1 | Counter equals zero |
| prd_o | output | 1 | Counter equals active period |
| dir_down_o | output | 1 | 1 while counting down |

## Verification
If the prescaler count is corrupted, the spacing between ticks changes in the very next divide window. The tick count over a whole number of windows exposes it, and so does the counter value reached after a fixed number of clocks. If the active period copy is wrong, the turnaround point moves. That appears as a wrong count or a missing period strobe within one counter cycle. Shadow-transfer timing errors show up as an extra or a missing zero step after a period write. A stale direction flag is visible at the first reversal in up-down mode.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int CNT_W = 16;
  localparam int DIV_W = 3;
  localparam int HSP_W = 3;

  // field positions in the control word
  localparam int MODE_LSB = 0;
  localparam int IMM_BIT  = 3;
  localparam int HSP_LSB  = 7;
  localparam int DIV_LSB  = 10;
  localparam int RUN_LSB  = 14;

  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_FREEZE = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RM_STOP_NOW   = 2'b00,
    RM_STOP_CYCLE = 2'b01,
    RM_FREE_A     = 2'b10,
    RM_FREE_B     = 2'b11
  } run_mode_e;

  typedef struct packed {
    run_mode_e        run;
    logic [DIV_W-1:0] clkdiv;
    logic [HSP_W-1:0] hsp;
    logic             prd_imm;
    cnt_mode_e        mode;
  } ctrl_t;
endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         tick_i,
  input  logic         at_zero_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] prd_act_o
);
  logic [W-1:0] prd_shd_q;
  logic         wr_ctrl, wr_prd, xfer;
  ctrl_t        ctrl_d;

  assign wr_ctrl = wr_en_i && !wr_sel_i;
  assign wr_prd  = wr_en_i &&  wr_sel_i;
  assign xfer    = !ctrl_o.prd_imm && tick_i && at_zero_i;

  always_comb begin
    ctrl_d.run     = run_mode_e'(wr_data_i[RUN_LSB +: 2]);
    ctrl_d.clkdiv  = wr_data_i[DIV_LSB +: DIV_W];
    ctrl_d.hsp     = wr_data_i[HSP_LSB +: HSP_W];
    ctrl_d.prd_imm = wr_data_i[IMM_BIT];
    ctrl_d.mode    = cnt_mode_e'(wr_data_i[MODE_LSB +: 2]);
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[13], wr_data_i[6:4], wr_data_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      prd_shd_q <= '0;
      prd_act_o <= '0;
    end else begin
      if (wr_ctrl) ctrl_o <= ctrl_d;
      if (wr_prd) prd_shd_q <= wr_data_i;
      if (wr_prd && ctrl_o.prd_imm) prd_act_o <= wr_data_i;
      else if (xfer)                prd_act_o <= prd_shd_q;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o.prd_imm && !(tick_i && at_zero_i)) |=> $stable(prd_act_o)); // R6
  AST_IMM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prd && ctrl_o.prd_imm) |=> (prd_act_o == $past(wr_data_i))); // R6
endmodule

// File: rtl/ptb_prescale.sv
module ptb_prescale
  import ptb_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int HW = HSP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] clkdiv_i,
  input  logic [HW-1:0] hsp_i,
  output logic          tick_o
);
  localparam int PS_W = (1 << DW) - 1 + HW + 2;

  logic [PS_W-1:0] ps_q, factor, div_m1;

  always_comb begin
    factor = (hsp_i == '0) ? PS_W'(1) : PS_W'({hsp_i, 1'b0});
    div_m1 = (factor << clkdiv_i) - PS_W'(1);
  end

  assign tick_o = (ps_q >= div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ps_q <= '0;
    else if (tick_o) ps_q <= '0;
    else             ps_q <= ps_q + PS_W'(1);
  end

  AST_PS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (ps_q == '0)); // R5
  AST_PS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> (ps_q == $past(ps_q) + PS_W'(1))); // R5
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         halt_i,
  input  cnt_mode_e    mode_i,
  input  run_mode_e    run_i,
  input  logic [W-1:0] prd_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_down_o
);
  logic         at_zero, at_top, stop, adv;
  logic [W-1:0] cnt_d;
  logic         dir_d;

  assign at_zero = (cnt_o == '0);
  assign at_top  = (cnt_o >= prd_i);
  assign stop    = halt_i && ((run_i == RM_STOP_NOW) ||
                              (run_i == RM_STOP_CYCLE && at_zero));
  assign adv     = tick_i && !stop;

  always_comb begin
    cnt_d = cnt_o;
    dir_d = dir_down_o;
    unique case (mode_i)
      CM_UP: begin
        dir_d = 1'b0;
        cnt_d = at_top ? '0 : cnt_o + W'(1);
      end
      CM_DOWN: begin
        dir_d = 1'b1;
        cnt_d = at_zero ? prd_i : cnt_o - W'(1);
      end
      CM_UPDOWN: begin
        if (!dir_down_o) begin
          if (at_top) begin
            dir_d = 1'b1;
            if (!at_zero) cnt_d = cnt_o - W'(1);
          end else begin
            cnt_d = cnt_o + W'(1);
          end
        end else begin
          if (at_zero) begin
            dir_d = 1'b0;
            if (prd_i != '0) cnt_d = cnt_o + W'(1);
          end else begin
            cnt_d = cnt_o - W'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      dir_down_o <= 1'b0;
    end else if (adv) begin
      cnt_o      <= cnt_d;
      dir_down_o <= dir_d;
    end
  end

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_UP && cnt_o < prd_i) |=> (cnt_o == $past(cnt_o) + W'(1))); // R1
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_DOWN && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - W'(1))); // R2
  AST_UD_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_UPDOWN && !dir_down_o && cnt_o == prd_i && prd_i != '0) |=> dir_down_o); // R3
  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_FREEZE) |=> $stable(cnt_o)); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_o) && $stable(dir_down_o))); // R5
  AST_HALT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && run_i == RM_STOP_NOW) |=> $stable(cnt_o)); // R7
  AST_DIR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_UP) |=> !dir_down_o); // R9
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         halt_i,
  output logic         tick_o,
  output logic [W-1:0] count_o,
  output logic         zero_o,
  output logic         prd_o,
  output logic         dir_down_o
);
  ctrl_t        ctrl;
  logic [W-1:0] prd_act;
  logic         tick;

  ptb_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick),
    .at_zero_i (zero_o),
    .ctrl_o    (ctrl),
    .prd_act_o (prd_act)
  );

  ptb_prescale #(.DW(DIV_W), .HW(HSP_W)) u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clkdiv_i (ctrl.clkdiv),
    .hsp_i    (ctrl.hsp),
    .tick_o   (tick)
  );

  ptb_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .halt_i     (halt_i),
    .mode_i     (ctrl.mode),
    .run_i      (ctrl.run),
    .prd_i      (prd_act),
    .cnt_o      (count_o),
    .dir_down_o (dir_down_o)
  );

  assign tick_o = tick;
  assign zero_o = (count_o == '0);
  assign prd_o  = (count_o == prd_act);

  AST_ZERO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !halt_i && ctrl.mode == CM_UP && prd_o) |=> zero_o); // R8
endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        halt = 1'b0;
  logic        tick, zero, prd, dir_dn;
  logic [15:0] count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_timebase u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .halt_i     (halt),
    .tick_o     (tick),
    .count_o    (count),
    .zero_o     (zero),
    .prd_o      (prd),
    .dir_down_o (dir_dn)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] per;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic        dir;
  } vec_t;

  // ctrl: bits 15:14 = 11 free run, bit 3 = 1 immediate load, bits 1:0 mode
  localparam vec_t VECS [12] = '{
    '{16'hC008, 16'd5, 8'd3, 16'd3, 1'b0},  // R1
    '{16'hC008, 16'd5, 8'd6, 16'd0, 1'b0},  // R1
    '{16'hC008, 16'd5, 8'd8, 16'd2, 1'b0},  // R1
    '{16'hC009, 16'd5, 8'd1, 16'd5, 1'b1},  // R2
    '{16'hC009, 16'd5, 8'd3, 16'd3, 1'b1},  // R2
    '{16'hC009, 16'd5, 8'd6, 16'd0, 1'b1},  // R2
    '{16'hC009, 16'd5, 8'd7, 16'd5, 1'b1},  // R2
    '{16'hC00A, 16'd3, 8'd2, 16'd2, 1'b0},  // R3
    '{16'hC00A, 16'd3, 8'd4, 16'd2, 1'b1},  // R3
    '{16'hC00A, 16'd3, 8'd6, 16'd0, 1'b1},  // R3
    '{16'hC00A, 16'd3, 8'd7, 16'd1, 1'b0},  // R3
    '{16'hC00B, 16'd5, 8'd10, 16'd0, 1'b0}  // R4
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // reset, then control then period; counter sits at zero afterwards
  task automatic cfg(logic [15:0] c, logic [15:0] p);
    halt = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    wr(1'b0, c);
    wr(1'b1, p);
  endtask

  task automatic tick_cnt(int cycles, output int t);
    t = 0;
    for (int i = 0; i < cycles; i++) begin
      if (tick) t++;
      @(negedge clk);
    end
  endtask

  initial begin
    int t;
    @(negedge clk); @(negedge clk);
    // R10 reset state
    chk("R10 count", count, 0);
    chk("R10 zero", zero, 1);
    chk("R10 dir", dir_dn, 0);
    chk("R10 prd", prd, 1);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      cfg(VECS[i].ctrl, VECS[i].per);
      run(int'(VECS[i].n));
      chk($sformatf("R1-4 vec%0d count", i), count, int'(VECS[i].cnt));
      chk($sformatf("R9 vec%0d dir", i), dir_dn, int'(VECS[i].dir));
    end

    // R5 prescaler ratios
    cfg(16'hC508, 16'd100); tick_cnt(64, t); chk("R5 div8", t, 8);
    cfg(16'hC188, 16'd100); tick_cnt(60, t); chk("R5 div6", t, 10);
    cfg(16'hC008, 16'd100); tick_cnt(20, t); chk("R5 div1", t, 20);
    cfg(16'hDF88, 16'd100); tick_cnt(5376, t); chk("R5 div1792", t, 3);
    cfg(16'hC508, 16'd100); run(80); chk("R5 count on ticks", count, 10);

    // R8 strobes
    cfg(16'hC008, 16'd5); run(5);
    chk("R8 prd at top", prd, 1); chk("R8 zero at top", zero, 0);
    run(1);
    chk("R8 zero after wrap", zero, 1); chk("R8 prd after wrap", prd, 0);

    // R6 shadow load: extra zero step, old period kept until zero
    cfg(16'hC000, 16'd5); run(3); chk("R6 shadow first", count, 2);
    wr(1'b1, 16'd2); run(2); chk("R6 shadow hold", count, 5);
    run(3); chk("R6 shadow applied", count, 2); chk("R6 prd strobe new", prd, 1);
    // R6 immediate load mid-run
    cfg(16'hC008, 16'd9); run(3);
    wr(1'b1, 16'd4); chk("R6 imm count", count, 4); chk("R6 imm prd", prd, 1);
    run(1); chk("R6 imm wrap", count, 0);

    // R7 halt behaviours
    cfg(16'h0008, 16'd9); run(3);
    halt = 1'b1; run(4); chk("R7 stop now", count, 3);
    halt = 1'b0; run(1); chk("R7 resume", count, 4);
    cfg(16'h4008, 16'd5); run(2);
    halt = 1'b1; run(10); chk("R7 stop at cycle end", count, 0);
    halt = 1'b0; run(1); chk("R7 resume after cycle", count, 1);
    cfg(16'hC008, 16'd9); run(3);
    halt = 1'b1; run(4); chk("R7 free run", count, 7);
    halt = 1'b0;

    // R11 select: period write does not alter mode; control write does not alter period
    cfg(16'hC009, 16'd7); run(1); chk("R11 period via sel1", count, 7);
    wr(1'b0, 16'hC008); chk("R11 ctrl keeps period", count, 6);
    run(1); chk("R11 mode now up", count, 7);

    // R10 asynchronous reset mid-run
    cfg(16'hC00A, 16'd9); run(5);
    rst_n = 1'b0; #1;
    chk("R10 async count", count, 0); chk("R10 async dir", dir_dn, 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule